// File: doc/BRIEF.md
# Multichannel integrating conversion sequencer

This block is the digital controller of a charge-integrating converter with a parameterised number of channels (twelve by default). Each channel has its own gate input that arms it. A start input begins the conversion phase. While converting, each armed channel counts clock cycles for as long as its run-down-active input, driven by an external analog comparator, stays high. The result is a 10-bit count plus an overflow bit. When every armed channel has finished its run-down, or when a fixed cycle budget runs out, the block raises a one-cycle done pulse. It also reports whether any channel reached a programmable threshold.

Results are held until a clear arrives. There are two clear paths. The fast-clear input aborts everything at once and then locks out gates and start for a settling interval. The dataway clear empties the results and makes the block ready again straight away. A global inhibit input masks the gates. Gates are not blocked after the first one: a channel gated again before the end of conversion re-arms and adds more run-down cycles to its count. Results are read one channel at a time through a registered address/data port.

Top module: `qconv_seq`

## Requirements
- R1: After a synchronous reset, `done_o` and `present_o` are 0, and every channel reads back as 0 (count and overflow).
- R2: An armed channel adds one to its count on each clock edge at which the block is converting and its `rundown_i` bit is high. A channel that was not gated keeps a count of 0, whatever its run-down input does.
- R3: A conversion begins on the edge that samples `start_i` high while idle or armed. A gate that is not followed by a start within `START_WIN` cycles is dropped. A start that arrives later converts with no channel armed.
- R4: Gates are not blocked after the first one. A gate that arrives on a channel during the armed or converting phase re-arms that channel, and its count keeps growing from its current value.
- R5: While `inhibit_i` is high, gate inputs are ignored and the channel stays unarmed.
- R6: A read returns {overflow, count}, with bit 10 holding the overflow flag and bits 9:0 the count. A count that would go past 1023 stays at 1023 and sets the overflow bit.
- R7: `done_o` is high for exactly one cycle. It rises on the first edge at which every armed channel has finished its run-down (its run-down input has gone high and then low again).
- R8: If the conversion has lasted `CONV_CYCLES` cycles, the conversion is forced to end. Any channel still counting then stops, and `done_o` pulses on the `CONV_CYCLES`-th edge after the conversion begins.
- R9: `present_o` is registered in the same cycle as `done_o`. It is 1 when at least one channel has a count greater than or equal to `thresh_i`, or has its overflow bit set. Otherwise it is 0 (the module is empty).
- R10: `fclr_i` zeroes every channel and `present_o` and aborts a running conversion without a done pulse. For `SETTLE_CYCLES` cycles afterwards, gates and start are ignored.
- R11: After done, results and `present_o` do not change under gates, start or run-down activity until `fclr_i` or `dclr_i` is applied. `dclr_i` zeroes them and returns the block to idle without a settling lockout.
- R12: `rd_data_o` shows the channel selected by `rd_sel_i` one clock after the address is applied. An address of `NCH` or above reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_i | input | NCH | Per-channel gate; arms the channel |
| inhibit_i | input | 1 | Masks all gate inputs while high |
| start_i | input | 1 | Begins the conversion phase |
| rundown_i | input | NCH | Per-channel run-down-active from the comparator |
| fclr_i | input | 1 | Fast clear with settling lockout |
| dclr_i | input | 1 | Dataway clear, no lockout |
| thresh_i | input | TW | Empty-module threshold in counts |
| rd_sel_i | input | $clog2(NCH) | Channel address for readout |
| rd_data_o | output | DW+1 | Registered {overflow, count} of the selected channel |
| done_o | output | 1 | One-cycle end-of-conversion pulse |
| present_o | output | 1 | Data-present flag (inverse of empty) |

## Verification
The bench re-gates a channel between two run-down bursts while another channel keeps the conversion open. A design that blocked the second gate would read 5 instead of 9. It fires a fast clear in the middle of a run-down and then tries a gate and start inside the settling window. A design without the lockout would produce a done pulse and a non-zero count there. Threshold tests cover the case where the count equals the threshold, a count just below it, and a threshold of zero. Getting the comparison direction wrong flips `present_o`. Further tests cover saturation past 1023, the cycle-budget forced finish, a start that comes too late, and stimulus after done. These catch a counter that wraps, a missing timeout, and results that change while held.

// File: rtl/qconv_pkg.sv
package qconv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_CONV,
    ST_HOLD,
    ST_SETTLE
  } seq_state_t;
endpackage

// File: rtl/qconv_chan.sv
// One channel: arm flag, run-down tracking and a saturating result counter.
module qconv_chan #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          arm,
  input  logic          run,
  input  logic          rd,
  output logic [DW-1:0] cnt_o,
  output logic          ovf_o,
  output logic          fin_o
);
  localparam logic [DW-1:0] CNT_MAX = {DW{1'b1}};

  logic armed_q;
  logic seen_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_o   <= '0;
      ovf_o   <= 1'b0;
      armed_q <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      if (run && armed_q && rd) begin
        seen_q <= 1'b1;
        if (cnt_o == CNT_MAX) ovf_o <= 1'b1;
        else                  cnt_o <= cnt_o + 1'b1;
      end
      // a later gate re-arms; run-down must be seen again before finishing
      if (arm) begin
        armed_q <= 1'b1;
        seen_q  <= 1'b0;
      end
    end
  end

  assign fin_o = !armed_q || (seen_q && !rd);
endmodule

// File: rtl/qconv_empty.sv
// Threshold comparison across all channels; reports whether any holds data.
module qconv_empty #(
  parameter int NCH = 12,
  parameter int DW  = 10,
  parameter int TW  = 7
) (
  input  logic [NCH-1:0][DW-1:0] cnt_all,
  input  logic [NCH-1:0]         ovf_all,
  input  logic [TW-1:0]          thresh,
  output logic                   any_hit
);
  localparam int CW = (DW > TW) ? DW + 1 : TW + 1;

  logic [NCH-1:0] hit;
  logic [CW-1:0]  thr_ext;

  assign thr_ext = CW'(thresh);

  for (genvar g = 0; g < NCH; g++) begin : g_cmp
    logic [CW-1:0] c_ext;
    assign c_ext  = CW'(cnt_all[g]);
    assign hit[g] = ovf_all[g] || (c_ext >= thr_ext);
  end

  assign any_hit = |hit;
endmodule

// File: rtl/qconv_ctrl.sv
// Sequencing: idle -> armed -> converting -> hold, with settle after fast clear.
module qconv_ctrl
  import qconv_pkg::*;
#(
  parameter int CONV_CYCLES   = 6000,
  parameter int SETTLE_CYCLES = 150,
  parameter int START_WIN     = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic fclr_i,
  input  logic dclr_i,
  input  logic inhibit_i,
  input  logic gate_any,
  input  logic all_fin,
  output logic gate_ok,
  output logic run_o,
  output logic chan_clr_o,
  output logic end_now_o
);
  localparam int BW = $clog2(CONV_CYCLES + 1);
  localparam int SW = $clog2(SETTLE_CYCLES + 1);
  localparam int WW = $clog2(START_WIN + 1);
  localparam logic [BW-1:0] B_LAST = BW'(CONV_CYCLES - 1);
  localparam logic [SW-1:0] S_LAST = SW'(SETTLE_CYCLES - 1);
  localparam logic [WW-1:0] W_LAST = WW'(START_WIN - 1);

  seq_state_t st_q;
  logic [BW-1:0] bcnt_q;
  logic [SW-1:0] scnt_q;
  logic [WW-1:0] wcnt_q;
  logic          accepting;
  logic          any_clr;
  logic          win_expire;

  assign accepting  = (st_q == ST_IDLE) || (st_q == ST_ARMED) || (st_q == ST_CONV);
  assign any_clr    = fclr_i || dclr_i;
  assign gate_ok    = accepting && !inhibit_i && !any_clr;
  assign win_expire = (st_q == ST_ARMED) && !start_i && !any_clr && (wcnt_q == W_LAST);
  assign end_now_o  = (st_q == ST_CONV) && !any_clr && (all_fin || bcnt_q == B_LAST);
  assign run_o      = (st_q == ST_CONV) && !any_clr && !end_now_o;
  assign chan_clr_o = any_clr || win_expire;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      bcnt_q <= '0;
      scnt_q <= '0;
      wcnt_q <= '0;
    end else if (fclr_i) begin
      st_q   <= ST_SETTLE;
      scnt_q <= '0;
    end else if (dclr_i && st_q != ST_SETTLE) begin
      st_q <= ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q   <= ST_CONV;
            bcnt_q <= '0;
          end else if (gate_any && gate_ok) begin
            st_q   <= ST_ARMED;
            wcnt_q <= '0;
          end
        end
        ST_ARMED: begin
          if (start_i) begin
            st_q   <= ST_CONV;
            bcnt_q <= '0;
          end else if (win_expire) begin
            st_q <= ST_IDLE;
          end else begin
            wcnt_q <= wcnt_q + 1'b1;
          end
        end
        ST_CONV: begin
          if (end_now_o) st_q <= ST_HOLD;
          else           bcnt_q <= bcnt_q + 1'b1;
        end
        ST_HOLD: st_q <= ST_HOLD;
        ST_SETTLE: begin
          if (scnt_q == S_LAST) st_q <= ST_IDLE;
          else                  scnt_q <= scnt_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qconv_seq.sv
module qconv_seq #(
  parameter int NCH           = 12,
  parameter int DW            = 10,
  parameter int TW            = 7,
  parameter int CONV_CYCLES   = 6000,
  parameter int SETTLE_CYCLES = 150,
  parameter int START_WIN     = 10,
  localparam int CHW          = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] gate_i,
  input  logic           inhibit_i,
  input  logic           start_i,
  input  logic [NCH-1:0] rundown_i,
  input  logic           fclr_i,
  input  logic           dclr_i,
  input  logic [TW-1:0]  thresh_i,
  input  logic [CHW-1:0] rd_sel_i,
  output logic [DW:0]    rd_data_o,
  output logic           done_o,
  output logic           present_o
);
  logic [NCH-1:0][DW-1:0] cnt_all;
  logic [NCH-1:0]         ovf_all;
  logic [NCH-1:0]         fin_all;
  logic                   gate_ok;
  logic                   run;
  logic                   chan_clr;
  logic                   end_now;
  logic                   any_hit;

  qconv_ctrl #(
    .CONV_CYCLES  (CONV_CYCLES),
    .SETTLE_CYCLES(SETTLE_CYCLES),
    .START_WIN    (START_WIN)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .fclr_i    (fclr_i),
    .dclr_i    (dclr_i),
    .inhibit_i (inhibit_i),
    .gate_any  (|gate_i),
    .all_fin   (&fin_all),
    .gate_ok   (gate_ok),
    .run_o     (run),
    .chan_clr_o(chan_clr),
    .end_now_o (end_now)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    qconv_chan #(.DW(DW)) u_chan (
      .clk  (clk),
      .rst  (rst),
      .clr  (chan_clr),
      .arm  (gate_i[g] && gate_ok),
      .run  (run),
      .rd   (rundown_i[g]),
      .cnt_o(cnt_all[g]),
      .ovf_o(ovf_all[g]),
      .fin_o(fin_all[g])
    );
  end

  qconv_empty #(.NCH(NCH), .DW(DW), .TW(TW)) u_empty (
    .cnt_all(cnt_all),
    .ovf_all(ovf_all),
    .thresh (thresh_i),
    .any_hit(any_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o    <= 1'b0;
      present_o <= 1'b0;
      rd_data_o <= '0;
    end else begin
      done_o <= end_now;
      if (fclr_i || dclr_i) present_o <= 1'b0;
      else if (end_now)     present_o <= any_hit;
      if (int'(rd_sel_i) < NCH) rd_data_o <= {ovf_all[rd_sel_i], cnt_all[rd_sel_i]};
      else                      rd_data_o <= '0;
    end
  end
endmodule

// File: rtl/qconv_seq_chk.sv
module qconv_seq_chk #(
  parameter int DW            = 10,
  parameter int SETTLE_CYCLES = 150
) (
  input logic        clk,
  input logic        rst,
  input logic        fclr_i,
  input logic        dclr_i,
  input logic        done_o,
  input logic        present_o,
  input logic [DW:0] rd_data_o
);
  localparam int LW = $clog2(SETTLE_CYCLES + 3) + 1;

  logic [LW-1:0] since_fclr;

  always_ff @(posedge clk) begin
    if (rst)                  since_fclr <= '1;
    else if (fclr_i)          since_fclr <= '0;
    else if (since_fclr != '1) since_fclr <= since_fclr + 1'b1;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R7
  AST_OVF_SATURATED: assert property (@(posedge clk) disable iff (rst)
    rd_data_o[DW] |-> (&rd_data_o[DW-1:0])); // R6
  AST_PRESENT_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(present_o) |-> done_o); // R9
  AST_PRESENT_HELD: assert property (@(posedge clk) disable iff (rst)
    $fell(present_o) |-> ($past(fclr_i) || $past(dclr_i))); // R11
  AST_CLEAR_ABORTS: assert property (@(posedge clk) disable iff (rst)
    (fclr_i || dclr_i) |=> (!done_o && !present_o)); // R10
  AST_SETTLE_LOCKOUT: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (since_fclr > LW'(SETTLE_CYCLES))); // R10
endmodule

bind qconv_seq qconv_seq_chk #(.DW(DW), .SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .fclr_i   (fclr_i),
  .dclr_i   (dclr_i),
  .done_o   (done_o),
  .present_o(present_o),
  .rd_data_o(rd_data_o)
);

// File: tb/qconv_seq_tb.sv
module qconv_seq_tb;
  localparam int NCH = 12, DW = 10, TW = 7, CHW = 4;
  localparam int CONV = 2000, SETTLE = 150, WIN = 10;

  logic           clk = 0;
  logic           rst = 1;
  logic [NCH-1:0] gate_i = '0;
  logic           inhibit_i = 0;
  logic           start_i = 0;
  logic [NCH-1:0] rundown_i = '0;
  logic           fclr_i = 0;
  logic           dclr_i = 0;
  logic [TW-1:0]  thresh_i = '0;
  logic [CHW-1:0] rd_sel_i = '0;
  logic [DW:0]    rd_data_o;
  logic           done_o;
  logic           present_o;

  int checks = 0;
  int fails  = 0;
  int lens[NCH];

  always #5 clk = ~clk;

  qconv_seq #(
    .NCH(NCH), .DW(DW), .TW(TW),
    .CONV_CYCLES(CONV), .SETTLE_CYCLES(SETTLE), .START_WIN(WIN)
  ) u_dut (
    .clk(clk), .rst(rst), .gate_i(gate_i), .inhibit_i(inhibit_i),
    .start_i(start_i), .rundown_i(rundown_i), .fclr_i(fclr_i),
    .dclr_i(dclr_i), .thresh_i(thresh_i), .rd_sel_i(rd_sel_i),
    .rd_data_o(rd_data_o), .done_o(done_o), .present_o(present_o)
  );

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic read_ch(int ch, output int v);
    rd_sel_i = CHW'(ch);
    tick();
    v = int'(rd_data_o);
  endtask

  task automatic dclear;
    dclr_i = 1; tick(); dclr_i = 0;
  endtask

  task automatic gate(logic [NCH-1:0] m);
    gate_i = m; tick(); gate_i = '0;
  endtask

  task automatic start;
    start_i = 1; tick(); start_i = 0;
  endtask

  task automatic clear_lens;
    for (int i = 0; i < NCH; i++) lens[i] = 0;
  endtask

  task automatic rundown(output int saw_done);
    int mx = 0;
    saw_done = 0;
    for (int i = 0; i < NCH; i++) if (lens[i] > mx) mx = lens[i];
    for (int t = 0; t < mx; t++) begin
      for (int i = 0; i < NCH; i++) rundown_i[i] = (t < lens[i]);
      tick();
      if (done_o) saw_done++;
    end
    rundown_i = '0;
  endtask

  task automatic wait_done(output int n, output int pres);
    n = 0;
    do begin
      tick();
      n++;
    end while (!done_o && n < CONV + 20);
    pres = present_o;
    tick();
    chk("R7", "done width", done_o, 0);
  endtask

  task automatic t_reset;
    int v;
    chk("R1", "done after reset", done_o, 0);
    chk("R1", "present after reset", present_o, 0);
    for (int i = 0; i < NCH; i++) begin
      read_ch(i, v);
      chk("R1", "channel after reset", v, 0);
    end
  endtask

  task automatic t_basic;
    int sd, n, p, v;
    thresh_i = 7'd10;
    clear_lens(); lens[0] = 5; lens[3] = 20;
    gate(12'h009);
    start();
    rundown(sd);
    chk("R7", "no early done", sd, 0);
    wait_done(n, p);
    chk("R7", "done one cycle after last run-down", n, 1);
    chk("R9", "present above threshold", p, 1);
    read_ch(0, v); chk("R2", "ch0 count", v, 5);
    read_ch(3, v); chk("R2", "ch3 count", v, 20);
    read_ch(1, v); chk("R2", "ungated ch1", v, 0);
    read_ch(12, v); chk("R12", "out of range address", v, 0);
    rd_sel_i = 4'd3; tick();
    chk("R12", "one cycle latency", int'(rd_data_o), 20);
    dclear();
  endtask

  task automatic t_hold;
    int sd, n, p, v;
    clear_lens(); lens[2] = 12;
    gate(12'h004); start(); rundown(sd); wait_done(n, p);
    gate(12'h004); start();
    clear_lens(); lens[2] = 6;
    rundown(sd);
    repeat (5) begin tick(); if (done_o) sd++; end
    chk("R11", "no done while holding", sd, 0);
    read_ch(2, v); chk("R11", "result held", v, 12);
    chk("R11", "present held", present_o, 1);
    dclear();
    read_ch(2, v); chk("R11", "dataway clear zeroes", v, 0);
    chk("R11", "dataway clear present", present_o, 0);
  endtask

  task automatic t_empty;
    int sd, n, p;
    thresh_i = 7'd50;
    clear_lens(); lens[2] = 30;
    gate(12'h004); start(); rundown(sd); wait_done(n, p);
    chk("R9", "below threshold is empty", p, 0);
    dclear();
    thresh_i = 7'd30;
    gate(12'h004); start(); rundown(sd); wait_done(n, p);
    chk("R9", "equal to threshold present", p, 1);
    dclear();
    thresh_i = 7'd31;
    gate(12'h004); start(); rundown(sd); wait_done(n, p);
    chk("R9", "one below threshold empty", p, 0);
    dclear();
    thresh_i = 7'd0;
    start();
    tick();
    chk("R9", "empty start done", done_o, 1);
    chk("R9", "zero threshold present", present_o, 1);
    dclear();
  endtask

  task automatic t_overflow;
    int sd, n, p, v;
    thresh_i = 7'd100;
    clear_lens(); lens[5] = 1030;
    gate(12'h020); start(); rundown(sd); wait_done(n, p);
    read_ch(5, v); chk("R6", "saturated with overflow", v, 2047);
    chk("R9", "overflow counts as present", p, 1);
    dclear();
    clear_lens(); lens[5] = 1023;
    gate(12'h020); start(); rundown(sd); wait_done(n, p);
    read_ch(5, v); chk("R6", "full scale no overflow", v, 1023);
    dclear();
  endtask

  task automatic t_inhibit;
    int sd, n, p, v;
    inhibit_i = 1; gate(12'h002); inhibit_i = 0;
    gate(12'h100);
    start();
    clear_lens(); lens[1] = 8; lens[8] = 4;
    rundown(sd); wait_done(n, p);
    read_ch(1, v); chk("R5", "inhibited gate ignored", v, 0);
    read_ch(8, v); chk("R5", "normal gate counts", v, 4);
    dclear();
  endtask

  task automatic t_regate;
    int v, sd = 0, n, p;
    gate(12'h090);
    start();
    for (int t = 0; t < 30; t++) begin
      rundown_i[7] = 1;
      rundown_i[4] = (t < 5) || (t >= 10 && t < 14);
      gate_i[4] = (t == 8);
      tick();
      if (done_o) sd++;
    end
    rundown_i = '0; gate_i = '0;
    chk("R4", "no done during re-gate", sd, 0);
    wait_done(n, p);
    read_ch(4, v); chk("R4", "re-gated channel accumulates", v, 9);
    read_ch(7, v); chk("R2", "long channel", v, 30);
    dclear();
  endtask

  task automatic t_fclr;
    int v, sd = 0, n, p;
    gate(12'h001); start();
    rundown_i[0] = 1;
    repeat (10) tick();
    fclr_i = 1; tick(); fclr_i = 0;
    if (done_o) sd++;
    read_ch(0, v); chk("R10", "fast clear zeroes mid conversion", v, 0);
    gate(12'h001); start();
    repeat (5) tick();
    rundown_i = '0;
    repeat (20) begin tick(); if (done_o) sd++; end
    chk("R10", "no done during settle", sd, 0);
    read_ch(0, v); chk("R10", "gate ignored during settle", v, 0);
    repeat (SETTLE) tick();
    clear_lens(); lens[0] = 7;
    gate(12'h001); start(); rundown(sd); wait_done(n, p);
    read_ch(0, v); chk("R10", "works after settle", v, 7);
    dclear();
  endtask

  task automatic t_window;
    int v;
    gate(12'h040);
    repeat (WIN + 2) tick();
    start();
    tick();
    chk("R3", "late start converts nothing", done_o, 1);
    rundown_i[6] = 1; repeat (5) tick(); rundown_i = '0;
    read_ch(6, v); chk("R3", "dropped gate", v, 0);
    dclear();
    gate(12'h040);
    repeat (WIN - 3) tick();
    start();
    clear_lens(); lens[6] = 3;
    begin int sd, n, p; rundown(sd); wait_done(n, p); end
    read_ch(6, v); chk("R3", "start inside window", v, 3);
    dclear();
  endtask

  task automatic t_budget;
    int n, p, v;
    gate(12'h200); start();
    rundown_i[9] = 1;
    wait_done(n, p);
    rundown_i = '0;
    chk("R8", "forced finish cycle", n, CONV);
    read_ch(9, v); chk("R8", "forced result", v, 2047);
    dclear();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 0;
    tick();
    t_reset();
    t_basic();
    t_hold();
    t_empty();
    t_overflow();
    t_inhibit();
    t_regate();
    t_fclr();
    t_window();
    t_budget();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule